// File: doc/BRIEF.md
# Double-Buffered Display Data Latch

This block holds the per-channel grayscale words and the global brightness value that a PWM engine consumes. A serial shift register (outside this block) assembles a full word in parallel, then raises a latch strobe. The block keeps two copies of the display data. The first stage takes new data at any moment. The second stage feeds the PWM engine and changes only at a display-period boundary. Software can therefore load a new frame without tearing the period that is running.

A select input picks what a strobe loads: display data or control settings. Control settings (blank, auto-repeat, timing reset, PWM mode) are single-buffered and act at once. While the output is blanked, nothing is on screen to protect. Blanking therefore forces data straight through to the second stage. A pending flag shows when the first stage holds data the second stage has not yet taken.

The shift bus is a plain parallel vector sampled on the strobe edge. The shift register always has a word ready when it strobes, so there is no valid/ready handshake and no back-pressure. The strobe is never refused and every rising edge is accepted.

Top module: `dbl_disp_latch`

## Requirements
- R1: After reset all grayscale and brightness outputs, all control outputs and the pending flag are 0.
- R2: A rising edge of `lat_i` with `sel_i`=0 copies `shift_data_i` into the first stage. Channel k comes from bits [12k+11:12k] and brightness from bits [198:192]. When blank is 0 and `period_end_i` is low, the outputs keep their old values and `pending_o` becomes 1 after that edge.
- R3: A clock with `period_end_i` high while data is pending copies the first stage to the outputs. It also clears `pending_o`, and both changes are visible after that clock edge.
- R4: Only the rising edge of `lat_i` loads data. Holding `lat_i` high while the bus changes loads nothing further.
- R5: A rising edge of `lat_i` with `sel_i`=1 loads the control outputs from `shift_data_i` bits [3:0] after that edge: bit0 blank, bit1 repeat, bit2 timing reset, bit3 PWM mode. It leaves the display outputs and `pending_o` unchanged.
- R6: A control write that changes blank from 0 to 1 copies pending first-stage data to the outputs on the same edge and clears `pending_o`.
- R7: A display write while blank is 1 loads the first and second stages together. The outputs show the new data after that edge and `pending_o` stays 0.
- R8: A display write on the same clock as `period_end_i` puts the newly written data on the outputs after that edge, with `pending_o` 0.
- R9: `period_end_i` with nothing pending leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_i | input | 1 | Latch strobe, rising edge loads |
| sel_i | input | 1 | 0 = display data, 1 = control bits |
| shift_data_i | input | 199 | Parallel shift register contents |
| period_end_i | input | 1 | One-cycle pulse on the last clock of a display period |
| gs_o | output | 192 | Second-stage grayscale, 16 x 12 bits |
| bc_o | output | 7 | Second-stage global brightness |
| blank_o | output | 1 | Blank control bit |
| rpt_o | output | 1 | Auto-repeat control bit |
| tmg_rst_o | output | 1 | Timing-reset control bit |
| pwm_mode_o | output | 1 | PWM mode control bit |
| pending_o | output | 1 | First stage holds untransferred data |

## Verification
The transfer path is tested in several situations:
- A write followed by a separate period end. This separates buffered from immediate loading.
- A period end with nothing pending. This shows that transfers are gated.
- A write on the same clock as the period end. This shows that new data wins over old.
- Writes under blank, and a blank raised over pending data. These show both override paths.

A strobe held high while the bus changes shows that only the edge loads data. Control writes placed between a pending write and its period end show that control bits act at once and leave the display stages alone. Every data pattern gives each channel a distinct value, so a swapped or shifted field is exposed.

// File: rtl/dbl_latch_pkg.sv
package dbl_latch_pkg;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic pwm_mode;
    logic tmg_rst;
    logic rpt;
    logic blank;
  } ctrl_t;

  typedef enum logic {
    SEL_DISP = 1'b0,
    SEL_CTRL = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ctrl_latch.sv
module ctrl_latch
  import dbl_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  ctrl_t wr_data_i,
  output ctrl_t ctrl_o,
  output logic  blank_set_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wr_data_i;
  end

  assign ctrl_o      = ctrl_q;
  assign blank_set_o = wr_i & wr_data_i.blank & ~ctrl_q.blank;

  // R5
  ctrl_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ctrl_o == $past(wr_data_i));
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_wr_i,
  input  logic period_end_i,
  input  logic blank_i,
  input  logic blank_set_i,
  output logic ld1_o,
  output logic ld2_shift_o,
  output logic ld2_s1_o,
  output logic pending_o
);
  logic pending_q;
  logic direct;

  assign direct      = blank_i | period_end_i;
  assign ld1_o       = disp_wr_i;
  assign ld2_shift_o = disp_wr_i & direct;
  assign ld2_s1_o    = ~disp_wr_i & pending_q & (period_end_i | blank_set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (disp_wr_i) pending_q <= ~direct;
    else if (ld2_s1_o)  pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_wr_i && !blank_i && !period_end_i) |=> pending_o);
  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_i |=> !pending_o);
  // R6
  blank_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_set_i |=> !pending_o);
  // R7
  blank_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_wr_i && blank_i) |=> !pending_o);
endmodule

// File: rtl/field_slice.sv
module field_slice #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld1_i,
  input  logic         ld2_shift_i,
  input  logic         ld2_s1_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     s1_q <= '0;
    else if (ld1_i) s1_q <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           s2_q <= '0;
    else if (ld2_shift_i) s2_q <= din_i;
    else if (ld2_s1_i)    s2_q <= s1_q;
  end

  assign q_o = s2_q;

  // R3
  s1_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld2_s1_i && !ld2_shift_i) |=> q_o == $past(s1_q));
  // R9
  s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld2_s1_i && !ld2_shift_i) |=> $stable(q_o));
endmodule

// File: rtl/dbl_disp_latch.sv
module dbl_disp_latch
  import dbl_latch_pkg::*;
#(
  parameter int NCH = 16,
  parameter int GSW = 12,
  parameter int BCW = 7,
  localparam int GS_BITS = NCH * GSW,
  localparam int DW = GS_BITS + BCW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lat_i,
  input  logic               sel_i,
  input  logic [DW-1:0]      shift_data_i,
  input  logic               period_end_i,
  output logic [GS_BITS-1:0] gs_o,
  output logic [BCW-1:0]     bc_o,
  output logic               blank_o,
  output logic               rpt_o,
  output logic               tmg_rst_o,
  output logic               pwm_mode_o,
  output logic               pending_o
);
  logic    lat_rise;
  logic    disp_wr;
  logic    ctrl_wr;
  logic    blank_set;
  logic    ld1;
  logic    ld2_shift;
  logic    ld2_s1;
  ctrl_t   ctrl;
  wr_sel_e sel;

  assign sel     = wr_sel_e'(sel_i);
  assign disp_wr = lat_rise & (sel == SEL_DISP);
  assign ctrl_wr = lat_rise & (sel == SEL_CTRL);

  strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (lat_i),
    .rise_o   (lat_rise)
  );

  ctrl_latch u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (ctrl_wr),
    .wr_data_i   (ctrl_t'(shift_data_i[CTRL_W-1:0])),
    .ctrl_o      (ctrl),
    .blank_set_o (blank_set)
  );

  xfer_ctrl u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_wr_i    (disp_wr),
    .period_end_i (period_end_i),
    .blank_i      (ctrl.blank),
    .blank_set_i  (blank_set),
    .ld1_o        (ld1),
    .ld2_shift_o  (ld2_shift),
    .ld2_s1_o     (ld2_s1),
    .pending_o    (pending_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_gs
    field_slice #(.W(GSW)) u_gs (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld1_i       (ld1),
      .ld2_shift_i (ld2_shift),
      .ld2_s1_i    (ld2_s1),
      .din_i       (shift_data_i[k*GSW +: GSW]),
      .q_o         (gs_o[k*GSW +: GSW])
    );
  end

  field_slice #(.W(BCW)) u_bc (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld1_i       (ld1),
    .ld2_shift_i (ld2_shift),
    .ld2_s1_i    (ld2_s1),
    .din_i       (shift_data_i[GS_BITS +: BCW]),
    .q_o         (bc_o)
  );

  assign blank_o    = ctrl.blank;
  assign rpt_o      = ctrl.rpt;
  assign tmg_rst_o  = ctrl.tmg_rst;
  assign pwm_mode_o = ctrl.pwm_mode;

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_wr && period_end_i) |=> ({bc_o, gs_o} == $past(shift_data_i) && !pending_o));
  // R5
  ctrl_keeps_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !blank_set) |=> ($stable(gs_o) && $stable(pending_o)));
endmodule

// File: tb/dbl_disp_latch_tb_top.sv
module dbl_disp_latch_tb_top;
  localparam int DW = 199;
  localparam int GB = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lat = 1'b0;
  logic          sel = 1'b0;
  logic [DW-1:0] sd = '0;
  logic          pe = 1'b0;
  logic [GB-1:0] gs;
  logic [6:0]    bc;
  logic          blank, rpt, tmg, pwm, pend;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  dbl_disp_latch dut_i (
    .clk(clk), .rst_n(rst_n), .lat_i(lat), .sel_i(sel), .shift_data_i(sd),
    .period_end_i(pe), .gs_o(gs), .bc_o(bc), .blank_o(blank), .rpt_o(rpt),
    .tmg_rst_o(tmg), .pwm_mode_o(pwm), .pending_o(pend)
  );

  function automatic logic [DW-1:0] pat(input int s);
    logic [DW-1:0] p;
    for (int k = 0; k < 16; k++) p[k*12 +: 12] = 12'(s*389 + k*1021 + 7);
    p[GB +: 7] = 7'(s*13 + 5);
    return p;
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [DW-1:0] d, input logic with_end);
    @(negedge clk);
    sel = s; sd = d; lat = 1'b1; pe = with_end;
    @(negedge clk);
    lat = 1'b0; pe = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); pe = 1'b1;
    @(negedge clk); pe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 display", {bc, gs}, '0);
    chk("R1 control", {pwm, tmg, rpt, blank}, '0);
    chk("R1 pending", pend, 0);
  endtask

  task automatic t_buffered();
    wr(1'b0, pat(1), 1'b0);
    chk("R2 outputs held", {bc, gs}, '0);
    chk("R2 pending set", pend, 1);
    repeat (3) @(negedge clk);
    chk("R2 still held", {bc, gs}, '0);
    pulse_end();
    chk("R3 transfer", {bc, gs}, pat(1));
    chk("R3 pending clear", pend, 0);
  endtask

  task automatic t_idle_end();
    sd = pat(20);
    pulse_end();
    chk("R9 no change", {bc, gs}, pat(1));
    chk("R9 pending", pend, 0);
  endtask

  task automatic t_hold();
    @(negedge clk); sel = 1'b0; sd = pat(2); lat = 1'b1;
    @(negedge clk); sd = pat(3);
    repeat (3) @(negedge clk);
    lat = 1'b0;
    pulse_end();
    chk("R4 only edge loads", {bc, gs}, pat(2));
  endtask

  task automatic t_ctrl();
    wr(1'b0, pat(4), 1'b0);
    wr(1'b1, DW'(4'b1010), 1'b0);
    chk("R5 control now", {pwm, tmg, rpt, blank}, 4'b1010);
    chk("R5 display kept", {bc, gs}, pat(2));
    chk("R5 pending kept", pend, 1);
    pulse_end();
    chk("R3 after ctrl", {bc, gs}, pat(4));
  endtask

  task automatic t_blank_set();
    wr(1'b0, pat(5), 1'b0);
    chk("R2 pending before blank", pend, 1);
    wr(1'b1, DW'(4'b0001), 1'b0);
    chk("R5 blank on", blank, 1);
    chk("R6 flush", {bc, gs}, pat(5));
    chk("R6 pending clear", pend, 0);
  endtask

  task automatic t_blank_write();
    wr(1'b0, pat(6), 1'b0);
    chk("R7 direct load", {bc, gs}, pat(6));
    chk("R7 pending low", pend, 0);
    wr(1'b1, DW'(4'b0000), 1'b0);
    chk("R5 blank off keeps data", {bc, gs}, pat(6));
  endtask

  task automatic t_coincide();
    wr(1'b0, pat(7), 1'b1);
    chk("R8 same-cycle", {bc, gs}, pat(7));
    chk("R8 pending", pend, 0);
    wr(1'b0, pat(8), 1'b0);
    wr(1'b0, pat(9), 1'b1);
    chk("R8 newest wins", {bc, gs}, pat(9));
    chk("R8 pending after", pend, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buffered();
    t_idle_end();
    t_hold();
    t_ctrl();
    t_blank_set();
    t_blank_write();
    t_coincide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule